// File: doc/BRIEF.md
# Load/Store Effective Address Generator

This block forms the memory address for a compact load/store instruction set with 16-bit encodings. Each request carries an addressing mode, an operand size, a load/store flag, a delay-slot marker, the base register value, the r0 value, the global base value, the program counter of the instruction and a raw displacement field. From these the block computes the effective address. For the auto-increment and auto-decrement modes it also computes the new base register value to write back. It flags any combination that the instruction set does not allow.

The operand size is 1, 2 or 4 bytes. Both displacement fields and the auto-update step are scaled by this size. A short 4-bit field serves the base-plus-displacement mode. A long 8-bit field serves the global-base and PC-relative modes. All results are registered: they appear one clock after a valid request, together with a valid strobe. The outputs hold between requests.

Top module: `ls_ea_gen`

## Requirements
- R1: After synchronous reset, res_valid, res_wb_en and res_illegal are 0 and res_addr is 0.
- R2: res_valid is 1 exactly in the cycle after a cycle with req_valid = 1. All result outputs keep their values in cycles that follow a cycle without a request. Back-to-back requests produce back-to-back results.
- R3: Mode 0 (register indirect) gives address = base. There is no writeback, and res_wb_val equals base.
- R4: Mode 1 (post-increment) gives address = base and writeback = base + size, with res_wb_en = 1. Size code 0 is 1 byte, code 1 is 2 bytes and code 2 is 4 bytes. A store (req_is_store = 1) in this mode is illegal.
- R5: Mode 2 (pre-decrement) gives address = writeback = base − size, with res_wb_en = 1. A load in this mode is illegal.
- R6: Mode 3 (base plus displacement) adds disp_raw[3:0] × size to base, giving reaches of 15, 30 and 60 bytes. disp_raw[7:4] has no effect in this mode.
- R7: Mode 4 (indexed) gives address = r0 + base.
- R8: Mode 5 (global base) gives address = gbr + disp_raw[7:0] × size. The longword reach is 1020 bytes.
- R9: Mode 6 (PC-relative) gives address = pc + 4 + disp_raw[7:0] × size. For longword size, address bits [1:0] are forced to 0.
- R10: Mode 6 is illegal for byte size, and illegal whenever req_in_delay_slot = 1.
- R11: All address and writeback arithmetic wraps modulo 2^32.
- R12: res_wb_en is 1 only for legal mode 1 and mode 2 requests. An illegal request never asserts it.
- R13: Mode code 7 and size code 3 are illegal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe |
| req_mode | input | 3 | Addressing mode code |
| req_size | input | 2 | Operand size code (0 byte, 1 word, 2 longword) |
| req_is_store | input | 1 | 1 for store, 0 for load |
| req_in_delay_slot | input | 1 | Instruction sits in a branch delay slot |
| base_val | input | 32 | Base register value |
| r0_val | input | 32 | r0 value (index) |
| gbr_val | input | 32 | Global base register value |
| pc_val | input | 32 | Instruction program counter |
| disp_raw | input | 8 | Raw unsigned displacement field |
| res_valid | output | 1 | Result strobe |
| res_addr | output | 32 | Effective address |
| res_wb_en | output | 1 | Base writeback enable |
| res_wb_val | output | 32 | Base writeback value |
| res_illegal | output | 1 | Illegal mode/size/direction combination |

## Verification
Every result is due exactly one clock after its request: the block holds a single register stage between the request inputs and all outputs. Each scenario task drives a request on a falling edge and lowers req_valid on the next falling edge. It then samples all outputs at that moment, half a period after the rising edge that captured them. The hold and back-to-back tests sample one and two falling edges later to confirm that res_valid follows req_valid and that the outputs stay unchanged in idle cycles.

// File: rtl/ls_ea_pkg.sv
package ls_ea_pkg;

    typedef enum logic [2:0] {
        AM_REG_IND  = 3'd0,
        AM_POST_INC = 3'd1,
        AM_PRE_DEC  = 3'd2,
        AM_REG_DISP = 3'd3,
        AM_INDEXED  = 3'd4,
        AM_GBR_DISP = 3'd5,
        AM_PC_REL   = 3'd6,
        AM_RSVD     = 3'd7
    } addr_mode_e;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_WORD = 2'd1,
        SZ_LONG = 2'd2,
        SZ_RSVD = 2'd3
    } op_size_e;

    // Pipeline offset seen by PC-relative accesses
    localparam int unsigned PC_BIAS = 4;

    // log2 of the operand size in bytes
    function automatic logic [1:0] size_shift(op_size_e sz);
        case (sz)
            SZ_BYTE: return 2'd0;
            SZ_WORD: return 2'd1;
            SZ_LONG: return 2'd2;
            default: return 2'd0;
        endcase
    endfunction

    function automatic logic size_ok(op_size_e sz);
        return sz != SZ_RSVD;
    endfunction

endpackage

// File: rtl/ea_disp_scaler.sv
module ea_disp_scaler
    import ls_ea_pkg::*;
#(
    parameter int unsigned AW     = 32,
    parameter int unsigned DISP_W = 4
) (
    input  op_size_e             size,
    input  logic [DISP_W-1:0]    disp,
    output logic [AW-1:0]        offset
);
    localparam int unsigned PAD_W = AW - DISP_W;

    logic [AW-1:0] disp_ext;

    always_comb begin
        disp_ext = {{PAD_W{1'b0}}, disp};
        offset   = disp_ext << size_shift(size);
    end
endmodule

// File: rtl/ea_legality.sv
module ea_legality
    import ls_ea_pkg::*;
(
    input  addr_mode_e mode,
    input  op_size_e   size,
    input  logic       is_store,
    input  logic       in_delay_slot,
    output logic       illegal
);
    always_comb begin
        illegal = !size_ok(size);
        case (mode)
            AM_POST_INC: if (is_store)  illegal = 1'b1;
            AM_PRE_DEC:  if (!is_store) illegal = 1'b1;
            AM_PC_REL:   if (size == SZ_BYTE || in_delay_slot) illegal = 1'b1;
            AM_RSVD:     illegal = 1'b1;
            default:     ;
        endcase
    end
endmodule

// File: rtl/ea_mode_mux.sv
module ea_mode_mux
    import ls_ea_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  addr_mode_e    mode,
    input  op_size_e      size,
    input  logic [AW-1:0] base,
    input  logic [AW-1:0] r0,
    input  logic [AW-1:0] gbr,
    input  logic [AW-1:0] pc,
    input  logic [AW-1:0] off_short,
    input  logic [AW-1:0] off_long,
    output logic [AW-1:0] addr,
    output logic          wb_req,
    output logic [AW-1:0] wb_val
);
    logic [AW-1:0] step;
    logic [AW-1:0] dec_val;
    logic [AW-1:0] pc_sum;

    always_comb begin
        step    = AW'(1) << size_shift(size);
        dec_val = base - step;
        pc_sum  = pc + AW'(PC_BIAS) + off_long;
        if (size == SZ_LONG) pc_sum[1:0] = 2'b00;

        addr   = base;
        wb_req = 1'b0;
        wb_val = base;
        case (mode)
            AM_REG_IND:  addr = base;
            AM_POST_INC: begin
                addr   = base;
                wb_req = 1'b1;
                wb_val = base + step;
            end
            AM_PRE_DEC: begin
                addr   = dec_val;
                wb_req = 1'b1;
                wb_val = dec_val;
            end
            AM_REG_DISP: addr = base + off_short;
            AM_INDEXED:  addr = r0 + base;
            AM_GBR_DISP: addr = gbr + off_long;
            AM_PC_REL:   addr = pc_sum;
            default:     addr = base;
        endcase
    end
endmodule

// File: rtl/ls_ea_gen.sv
module ls_ea_gen
    import ls_ea_pkg::*;
#(
    parameter int unsigned AW      = 32,
    parameter int unsigned SDISP_W = 4,
    parameter int unsigned LDISP_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [2:0]         req_mode,
    input  logic [1:0]         req_size,
    input  logic               req_is_store,
    input  logic               req_in_delay_slot,
    input  logic [AW-1:0]      base_val,
    input  logic [AW-1:0]      r0_val,
    input  logic [AW-1:0]      gbr_val,
    input  logic [AW-1:0]      pc_val,
    input  logic [LDISP_W-1:0] disp_raw,
    output logic               res_valid,
    output logic [AW-1:0]      res_addr,
    output logic               res_wb_en,
    output logic [AW-1:0]      res_wb_val,
    output logic               res_illegal
);
    addr_mode_e    mode;
    op_size_e      size;
    logic [AW-1:0] off_short;
    logic [AW-1:0] off_long;
    logic [AW-1:0] nxt_addr;
    logic [AW-1:0] nxt_wb_val;
    logic          nxt_wb_req;
    logic          nxt_illegal;

    assign mode = addr_mode_e'(req_mode);
    assign size = op_size_e'(req_size);

    ea_disp_scaler #(.AW(AW), .DISP_W(SDISP_W)) u_short_scale (
        .size   (size),
        .disp   (disp_raw[SDISP_W-1:0]),
        .offset (off_short)
    );

    ea_disp_scaler #(.AW(AW), .DISP_W(LDISP_W)) u_long_scale (
        .size   (size),
        .disp   (disp_raw),
        .offset (off_long)
    );

    ea_legality u_legal (
        .mode          (mode),
        .size          (size),
        .is_store      (req_is_store),
        .in_delay_slot (req_in_delay_slot),
        .illegal       (nxt_illegal)
    );

    ea_mode_mux #(.AW(AW)) u_mux (
        .mode      (mode),
        .size      (size),
        .base      (base_val),
        .r0        (r0_val),
        .gbr       (gbr_val),
        .pc        (pc_val),
        .off_short (off_short),
        .off_long  (off_long),
        .addr      (nxt_addr),
        .wb_req    (nxt_wb_req),
        .wb_val    (nxt_wb_val)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid   <= 1'b0;
            res_addr    <= '0;
            res_wb_en   <= 1'b0;
            res_wb_val  <= '0;
            res_illegal <= 1'b0;
        end else begin
            res_valid <= req_valid;
            if (req_valid) begin
                res_addr    <= nxt_addr;
                res_wb_val  <= nxt_wb_val;
                res_illegal <= nxt_illegal;
                res_wb_en   <= nxt_wb_req && !nxt_illegal;
            end
        end
    end

    // R2
    valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> res_valid);
    // R2
    valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> (!res_valid && $stable(res_addr) && $stable(res_wb_en)));
    // R12
    wb_suppress_chk: assert property (@(posedge clk) disable iff (rst)
        res_illegal |-> !res_wb_en);
    // R12
    wb_mode_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && res_wb_en == 1'b0 && 1'b1) |=> (res_wb_en |->
            ($past(req_mode) == 3'(AM_POST_INC) || $past(req_mode) == 3'(AM_PRE_DEC))));
    // R4
    post_inc_step_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 3'(AM_POST_INC) && req_size != 2'(SZ_RSVD) && !req_is_store)
        |=> (res_wb_val - res_addr == (AW'(1) << $past(req_size))));
    // R5
    pre_dec_same_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 3'(AM_PRE_DEC) && req_size != 2'(SZ_RSVD) && req_is_store)
        |=> (res_wb_en && res_wb_val == res_addr));
    // R9
    pc_long_align_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mode == 3'(AM_PC_REL) && req_size == 2'(SZ_LONG))
        |=> (res_addr[1:0] == 2'b00));
endmodule

// File: tb/sim_ls_ea_gen.sv
module sim_ls_ea_gen;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid;
    logic [2:0]  req_mode;
    logic [1:0]  req_size;
    logic        req_is_store;
    logic        req_in_delay_slot;
    logic [31:0] base_val, r0_val, gbr_val, pc_val;
    logic [7:0]  disp_raw;
    logic        res_valid;
    logic [31:0] res_addr;
    logic        res_wb_en;
    logic [31:0] res_wb_val;
    logic        res_illegal;

    int errors = 0;
    int checks = 0;
    int cycles = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ls_ea_gen u0 (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_mode(req_mode),
        .req_size(req_size), .req_is_store(req_is_store),
        .req_in_delay_slot(req_in_delay_slot), .base_val(base_val),
        .r0_val(r0_val), .gbr_val(gbr_val), .pc_val(pc_val), .disp_raw(disp_raw),
        .res_valid(res_valid), .res_addr(res_addr), .res_wb_en(res_wb_en),
        .res_wb_val(res_wb_val), .res_illegal(res_illegal)
    );

    task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    // drive at falling edge; result sampled at the next falling edge
    task automatic issue(logic [2:0] m, logic [1:0] s, logic st, logic ds,
                         logic [31:0] b, logic [31:0] r0, logic [31:0] g,
                         logic [31:0] pc, logic [7:0] d);
        req_valid = 1'b1; req_mode = m; req_size = s; req_is_store = st;
        req_in_delay_slot = ds; base_val = b; r0_val = r0; gbr_val = g;
        pc_val = pc; disp_raw = d;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    task automatic expect_ok(string tag, logic [31:0] a, logic we, logic [31:0] wv);
        check(tag, "valid", 32'(res_valid), 32'd1);
        check(tag, "illegal", 32'(res_illegal), 32'd0);
        check(tag, "addr", res_addr, a);
        check(tag, "wb_en", 32'(res_wb_en), 32'(we));
        check(tag, "wb_val", res_wb_val, wv);
    endtask

    task automatic expect_bad(string tag);
        check(tag, "illegal", 32'(res_illegal), 32'd1);
        check(tag, "wb_en", 32'(res_wb_en), 32'd0);
    endtask

    task automatic t_reset();
        check("R1", "valid", 32'(res_valid), 0);
        check("R1", "addr", res_addr, 0);
        check("R1", "wb_en", 32'(res_wb_en), 0);
        check("R1", "illegal", 32'(res_illegal), 0);
    endtask

    task automatic t_reg_ind();
        issue(3'd0, 2'd1, 1'b0, 1'b0, 32'h1000_0010, 32'h5, 32'h6, 32'h7, 8'hFF);
        expect_ok("R3", 32'h1000_0010, 1'b0, 32'h1000_0010);
    endtask

    task automatic t_post_inc();
        issue(3'd1, 2'd2, 1'b0, 1'b0, 32'h2000, 0, 0, 0, 0);
        expect_ok("R4", 32'h2000, 1'b1, 32'h2004);
        issue(3'd1, 2'd0, 1'b0, 1'b0, 32'h2000, 0, 0, 0, 0);
        expect_ok("R4", 32'h2000, 1'b1, 32'h2001);
        issue(3'd1, 2'd1, 1'b1, 1'b0, 32'h2000, 0, 0, 0, 0);
        expect_bad("R4");
    endtask

    task automatic t_pre_dec();
        issue(3'd2, 2'd1, 1'b1, 1'b0, 32'h3000, 0, 0, 0, 0);
        expect_ok("R5", 32'h2FFE, 1'b1, 32'h2FFE);
        issue(3'd2, 2'd2, 1'b1, 1'b0, 32'h100, 0, 0, 0, 0);
        expect_ok("R5", 32'hFC, 1'b1, 32'hFC);
        issue(3'd2, 2'd2, 1'b0, 1'b0, 32'h100, 0, 0, 0, 0);
        expect_bad("R5");
    endtask

    task automatic t_reg_disp();
        issue(3'd3, 2'd0, 1'b0, 1'b0, 32'h4000, 0, 0, 0, 8'h0F);
        expect_ok("R6", 32'h400F, 1'b0, 32'h4000);
        issue(3'd3, 2'd1, 1'b1, 1'b0, 32'h4000, 0, 0, 0, 8'h0F);
        expect_ok("R6", 32'h401E, 1'b0, 32'h4000);
        issue(3'd3, 2'd2, 1'b0, 1'b0, 32'h4000, 0, 0, 0, 8'h0F);
        expect_ok("R6", 32'h403C, 1'b0, 32'h4000);
        issue(3'd3, 2'd2, 1'b0, 1'b0, 32'h4000, 0, 0, 0, 8'hA5);
        expect_ok("R6", 32'h4014, 1'b0, 32'h4000);
    endtask

    task automatic t_indexed();
        issue(3'd4, 2'd2, 1'b0, 1'b0, 32'h1000, 32'h40, 0, 0, 8'h33);
        expect_ok("R7", 32'h1040, 1'b0, 32'h1000);
    endtask

    task automatic t_gbr();
        issue(3'd5, 2'd2, 1'b0, 1'b0, 32'h9, 0, 32'h8000, 0, 8'hFF);
        expect_ok("R8", 32'h83FC, 1'b0, 32'h9);
        issue(3'd5, 2'd0, 1'b1, 1'b0, 32'h9, 0, 32'h8000, 0, 8'h80);
        expect_ok("R8", 32'h8080, 1'b0, 32'h9);
    endtask

    task automatic t_pc_rel();
        issue(3'd6, 2'd2, 1'b0, 1'b0, 32'h1, 0, 0, 32'h1002, 8'h01);
        expect_ok("R9", 32'h1008, 1'b0, 32'h1);
        issue(3'd6, 2'd1, 1'b0, 1'b0, 32'h1, 0, 0, 32'h1002, 8'h03);
        expect_ok("R9", 32'h100C, 1'b0, 32'h1);
        issue(3'd6, 2'd0, 1'b0, 1'b0, 32'h1, 0, 0, 32'h1000, 8'h01);
        expect_bad("R10");
        issue(3'd6, 2'd2, 1'b0, 1'b1, 32'h1, 0, 0, 32'h1000, 8'h01);
        expect_bad("R10");
    endtask

    task automatic t_wrap();
        issue(3'd1, 2'd2, 1'b0, 1'b0, 32'hFFFF_FFFE, 0, 0, 0, 0);
        expect_ok("R11", 32'hFFFF_FFFE, 1'b1, 32'h2);
        issue(3'd2, 2'd0, 1'b1, 1'b0, 32'h0, 0, 0, 0, 0);
        expect_ok("R11", 32'hFFFF_FFFF, 1'b1, 32'hFFFF_FFFF);
        issue(3'd4, 2'd0, 1'b0, 1'b0, 32'hFFFF_FFF0, 32'h20, 0, 0, 0);
        expect_ok("R11", 32'h10, 1'b0, 32'hFFFF_FFF0);
    endtask

    task automatic t_reserved();
        issue(3'd7, 2'd2, 1'b0, 1'b0, 32'h10, 0, 0, 0, 0);
        expect_bad("R13");
        issue(3'd1, 2'd3, 1'b0, 1'b0, 32'h10, 0, 0, 0, 0);
        expect_bad("R13");
        // R12: legal non-update mode keeps wb_en low
        issue(3'd0, 2'd2, 1'b1, 1'b0, 32'h10, 0, 0, 0, 0);
        expect_ok("R12", 32'h10, 1'b0, 32'h10);
    endtask

    task automatic t_timing();
        // back-to-back requests
        req_valid = 1'b1; req_mode = 3'd4; req_size = 2'd2; req_is_store = 1'b0;
        req_in_delay_slot = 1'b0; base_val = 32'h100; r0_val = 32'h1;
        gbr_val = 0; pc_val = 0; disp_raw = 0;
        @(negedge clk);
        expect_ok("R2", 32'h101, 1'b0, 32'h100);
        r0_val = 32'h2;
        @(negedge clk);
        req_valid = 1'b0;
        expect_ok("R2", 32'h102, 1'b0, 32'h100);
        r0_val = 32'h77;
        @(negedge clk);
        check("R2", "idle valid", 32'(res_valid), 0);
        check("R2", "hold addr", res_addr, 32'h102);
        @(negedge clk);
        check("R2", "hold addr2", res_addr, 32'h102);
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000) begin
                errors++; checks++;
                $display("FAIL watchdog: actual=%0d expected<100000", cycles);
                $display("Result: errors=%0d of %0d checks", errors, checks);
                $finish;
            end
        end
    end

    initial begin
        rst = 1'b1; req_valid = 1'b0; req_mode = 0; req_size = 0;
        req_is_store = 0; req_in_delay_slot = 0; base_val = 0; r0_val = 0;
        gbr_val = 0; pc_val = 0; disp_raw = 0;
        repeat (3) @(negedge clk);
        t_reset();
        rst = 1'b0;
        @(negedge clk);
        t_reg_ind();
        t_post_inc();
        t_pre_dec();
        t_reg_disp();
        t_indexed();
        t_gbr();
        t_pc_rel();
        t_wrap();
        t_reserved();
        t_timing();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule